// File: doc/BRIEF.md
# Transmit Byte Queue with Trigger-Level Flag

This block is the byte queue that sits in front of a serial transmitter. Software pushes bytes into it through a register-style write port. A DMA engine can push through a second write port. The transmit shift stage pulls bytes out in arrival order through a valid/ready stream. The queue holds up to 16 bytes by default. Its fill count is published in the upper byte of a 16-bit status word.

The block keeps a "room available" flag. The flag does not compare the fill count against zero. It compares it against a trigger level that software picks with a 2-bit select. The flag goes high when a byte leaves for the shifter and the fill count drops to or below the trigger level. It goes low only when the fill count is above the trigger level and one of two things has happened:
- Software read the flag as 1 and then wrote 0 to it.
- The DMA port pushed a byte.

While the flag is high, software knows it can push (depth minus trigger level) more bytes without loss.

Back-pressure rules:
- `cpu_wr_ready` is high whenever a slot is free. A CPU beat offered while it is low is discarded, not held.
- `dma_wr_ready` also drops while a CPU beat is offered, because the CPU port wins the single push slot of each cycle. The DMA source is expected to hold its beat until ready.
- On the output side, a byte leaves only on a cycle with both `tx_valid` and `tx_ready` high.

Top module: `txf_trig_fifo`

## Requirements
- R1: The queue holds 16 bytes. When it is full, `cpu_wr_ready` is low and a CPU write is dropped, leaving the count and the stored bytes unchanged.
- R2: `tx_valid` is high exactly when the count is nonzero. `tx_data` presents the oldest stored byte, and bytes leave in first-in first-out order, one per cycle with `tx_valid` and `tx_ready` both high.
- R3: After reset the flag is 1, the count is 0 and `tx_valid` is low.
- R4: The select `trig_sel` maps to trigger levels as follows: 2'b00 gives 8, 2'b01 gives 4, 2'b10 gives 2, 2'b11 gives 0.
- R5: A cycle that hands a byte to the shifter and leaves the count at or below the trigger level sets the flag to 1 at that clock edge.
- R6: A pulse on `flag_rd` while the flag is 1, followed in a later cycle by a pulse on `flag_wr0`, clears the flag. The clear happens at the first edge where the resulting count is above the trigger level, which may be the edge of the `flag_wr0` pulse itself.
- R7: A `flag_wr0` pulse that has no `flag_rd` pulse seen with the flag at 1 since the flag last went high has no effect on the flag.
- R8: An accepted DMA push whose resulting count is above the trigger level clears the flag at that edge, with no read/write-0 sequence.
- R9: A cycle with one accepted push and one pop leaves the count unchanged. The flag rules are applied to that resulting count.
- R10: `status_word[15:8]` carries the current count and `status_word[7:0]` reads 0.
- R11: When both write ports offer a byte in the same cycle, the CPU byte is taken and `dma_wr_ready` is low for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_sel | input | 2 | Trigger-level select |
| cpu_wr_valid | input | 1 | CPU byte offered |
| cpu_wr_ready | output | 1 | Slot free; CPU byte accepted when valid |
| cpu_wr_data | input | 8 | CPU byte |
| dma_wr_valid | input | 1 | DMA byte offered |
| dma_wr_ready | output | 1 | DMA byte accepted when valid |
| dma_wr_data | input | 8 | DMA byte |
| tx_valid | output | 1 | A byte is available for the shifter |
| tx_ready | input | 1 | Shifter takes the byte |
| tx_data | output | 8 | Oldest stored byte |
| flag_rd | input | 1 | Status read strobe (arms the clear when the flag is 1) |
| flag_wr0 | input | 1 | Write-0 strobe to the flag |
| tde_flag | output | 1 | Room-available flag |
| status_word | output | 16 | Fill count in the upper byte, zero in the lower byte |

## Verification
The bench builds the block with its default 8-bit width and 16-entry depth. With these values a full queue can be reached in 16 writes, so the dropped-write boundary is tested directly. All four trigger levels are driven, so each one becomes a visible flag transition:
- half depth (8)
- quarter depth (4)
- eighth depth (2)
- zero, where any stored byte is above the trigger

A long random phase mixes the following, all against a queue-based model:
- both write ports
- pops
- status reads and write-0 pulses
- trigger changes

// File: rtl/txf_pkg.sv
`timescale 1ns/1ps
package txf_pkg;

  typedef enum logic [1:0] {
    TRIG_HALF    = 2'b00,
    TRIG_QUARTER = 2'b01,
    TRIG_EIGHTH  = 2'b10,
    TRIG_NONE    = 2'b11
  } trig_sel_e;

  // trigger level in bytes as a fraction of the queue depth
  function automatic int unsigned trig_level(input trig_sel_e s, input int unsigned depth);
    case (s)
      TRIG_HALF:    return depth / 2;
      TRIG_QUARTER: return depth / 4;
      TRIG_EIGHTH:  return depth / 8;
      default:      return 0;
    endcase
  endfunction

endpackage

// File: rtl/txf_store.sv
`timescale 1ns/1ps
module txf_store #(
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_n, rptr_n;

  // pointer advance: free wrap for power-of-two depth, compare otherwise
  if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
    assign wptr_n = wptr + AW'(1);
    assign rptr_n = rptr + AW'(1);
  end else begin : g_wrap
    assign wptr_n = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
    assign rptr_n = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr_n;
      if (pop)  rptr <= rptr_n;
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign pop_data = mem[rptr];

  // R1: the count never passes the depth
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R1: the parent never pushes into a full queue
  p_push_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)));

  // R2: a lone pop removes exactly one byte
  p_pop_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - CW'(1)));

  // R9: push with pop keeps the count
  p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));

endmodule

// File: rtl/txf_flag.sv
`timescale 1ns/1ps
module txf_flag #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_ev,
  input  logic          dma_ev,
  input  logic [CW-1:0] cnt_next,
  input  logic [CW-1:0] trig,
  input  logic          rd_stb,
  input  logic          wr0_stb,
  output logic          tde
);

  logic armed;   // flag was read as 1 since it last went high
  logic pend;    // write-0 accepted, waiting for count above trigger
  logic above, set_ev, wr0_ok, clr_ev;

  always_comb begin
    above  = cnt_next > trig;
    set_ev = pop_ev && !above;
    wr0_ok = wr0_stb && armed;
    clr_ev = tde && above && (pend || wr0_ok || dma_ev);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tde   <= 1'b1;
      armed <= 1'b0;
      pend  <= 1'b0;
    end else if (set_ev) begin
      tde   <= 1'b1;
      armed <= 1'b0;
      pend  <= 1'b0;
    end else if (clr_ev) begin
      tde   <= 1'b0;
      armed <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (rd_stb && tde) armed <= 1'b1;
      if (wr0_ok)        pend  <= 1'b1;
    end
  end

  // R5: pop landing at or below trigger raises the flag
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && !above) |=> tde);

  // R6: the flag only falls when the resulting count was above trigger
  p_fall_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tde) |-> $past(above));

  // R7: unarmed write-0 without DMA leaves the flag high
  p_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tde && wr0_stb && !armed && !pend && !dma_ev) |=> tde);

  // R8: DMA push above trigger drops the flag
  p_dma_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ev && above) |=> !tde);

endmodule

// File: rtl/txf_trig_fifo.sv
`timescale 1ns/1ps
module txf_trig_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   trig_sel,
  input  logic         cpu_wr_valid,
  output logic         cpu_wr_ready,
  input  logic [W-1:0] cpu_wr_data,
  input  logic         dma_wr_valid,
  output logic         dma_wr_ready,
  input  logic [W-1:0] dma_wr_data,
  output logic         tx_valid,
  input  logic         tx_ready,
  output logic [W-1:0] tx_data,
  input  logic         flag_rd,
  input  logic         flag_wr0,
  output logic         tde_flag,
  output logic [15:0]  status_word
);

  logic [CW-1:0] count, cnt_next, trig_lvl;
  logic          room, cpu_push, dma_push, push, pop;
  logic [W-1:0]  push_data;

  assign trig_lvl = CW'(txf_pkg::trig_level(txf_pkg::trig_sel_e'(trig_sel), DEPTH));

  // one push slot per cycle, CPU first
  assign room         = count < CW'(DEPTH);
  assign cpu_wr_ready = room;
  assign dma_wr_ready = room && !cpu_wr_valid;
  assign cpu_push     = cpu_wr_valid && room;
  assign dma_push     = dma_wr_valid && dma_wr_ready;
  assign push         = cpu_push || dma_push;
  assign push_data    = cpu_push ? cpu_wr_data : dma_wr_data;

  assign tx_valid = count != '0;
  assign pop      = tx_valid && tx_ready;

  always_comb begin
    cnt_next = count;
    if (push && !pop)      cnt_next = count + CW'(1);
    else if (pop && !push) cnt_next = count - CW'(1);
  end

  txf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .pop_data  (tx_data),
    .count     (count)
  );

  txf_flag #(.CW(CW)) u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop_ev   (pop),
    .dma_ev   (dma_push),
    .cnt_next (cnt_next),
    .trig     (trig_lvl),
    .rd_stb   (flag_rd),
    .wr0_stb  (flag_wr0),
    .tde      (tde_flag)
  );

  assign status_word[15:8] = 8'(count);
  assign status_word[7:0]  = 8'h00;

  // R11: CPU beat blocks the DMA port
  p_cpu_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_valid |-> !dma_wr_ready);

  // R2: a stalled head byte stays put
  p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R1: a full queue with no pop stays full
  p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr_ready && !pop) |=> !cpu_wr_ready);

endmodule

// File: tb/sim_txf_trig_fifo.sv
`timescale 1ns/1ps
module sim_txf_trig_fifo;

  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] tsel = 2'b00;
  logic       cv = 0, dv = 0, tr = 0, rd = 0, w0 = 0;
  logic [7:0] cd = 0, dd = 0;
  logic       cpu_wr_ready, dma_wr_ready, tx_valid, tde_flag;
  logic [7:0] tx_data;
  logic [15:0] status_word;

  txf_trig_fifo u0 (
    .clk(clk), .rst_n(rst_n), .trig_sel(tsel),
    .cpu_wr_valid(cv), .cpu_wr_ready(cpu_wr_ready), .cpu_wr_data(cd),
    .dma_wr_valid(dv), .dma_wr_ready(dma_wr_ready), .dma_wr_data(dd),
    .tx_valid(tx_valid), .tx_ready(tr), .tx_data(tx_data),
    .flag_rd(rd), .flag_wr0(w0), .tde_flag(tde_flag), .status_word(status_word)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] q[$];
  bit mflag = 1, marm = 0, mpend = 0;

  // R4 encodings
  function automatic int trigv(logic [1:0] s);
    case (s) 2'b00: return 8; 2'b01: return 4; 2'b10: return 2; default: return 0; endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: inputs already set at a falling edge
  task automatic cyc();
    int tv, ns;
    bit acpu, adma, pp, above;
    #1;
    chk("R1", "cpu_wr_ready", int'(cpu_wr_ready), int'(q.size() < DEPTH));
    chk("R11", "dma_wr_ready", int'(dma_wr_ready), int'(q.size() < DEPTH && !cv));
    tv   = trigv(tsel);
    acpu = cv && q.size() < DEPTH;
    adma = dv && !cv && q.size() < DEPTH;
    pp   = tr && q.size() > 0;
    if (pp) void'(q.pop_front());
    if (acpu) q.push_back(cd);
    else if (adma) q.push_back(dd);
    ns = q.size();
    above = ns > tv;
    if (pp && !above) begin
      mflag = 1; marm = 0; mpend = 0;
    end else if (mflag && above && (mpend || (w0 && marm) || adma)) begin
      mflag = 0; marm = 0; mpend = 0;
    end else begin
      if (w0 && marm) mpend = 1;
      if (rd && mflag) marm = 1;
    end
    @(negedge clk);
    chk("R10", "status_word", int'(status_word), q.size() * 256);
    chk("R2", "tx_valid", int'(tx_valid), int'(q.size() != 0));
    if (q.size() != 0) chk("R2", "tx_data", int'(tx_data), int'(q[0]));
    chk("R5", "tde_flag", int'(tde_flag), int'(mflag));
    cv = 0; dv = 0; tr = 0; rd = 0; w0 = 0;
  endtask

  task automatic pop_n(int n);
    for (int i = 0; i < n; i++) begin tr = 1; cyc(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "flag after reset", int'(tde_flag), 1);
    chk("R3", "count after reset", int'(status_word[15:8]), 0);
    chk("R3", "tx_valid after reset", int'(tx_valid), 0);

    // trigger 8: fill to full, then one extra write is dropped
    tsel = 2'b00;
    for (int i = 0; i < DEPTH; i++) begin cv = 1; cd = 8'(8'h30 + i); cyc(); end
    cv = 1; cd = 8'hEE; cyc();
    chk("R1", "count after full write", int'(status_word[15:8]), 16);
    chk("R1", "head after full write", int'(tx_data), 8'h30);

    w0 = 1; cyc();
    chk("R7", "flag after unarmed write0", int'(tde_flag), 1);
    rd = 1; cyc();
    w0 = 1; cyc();
    chk("R6", "flag after read then write0", int'(tde_flag), 0);

    pop_n(7);
    chk("R6", "flag at count 9", int'(tde_flag), 0);
    pop_n(1);
    chk("R4", "flag set at trigger 8", int'(tde_flag), 1);

    // trigger 0: DMA push clears
    tsel = 2'b11; dv = 1; dd = 8'hA5; cyc();
    chk("R8", "flag after dma push", int'(tde_flag), 0);
    cv = 1; cd = 8'h5A; tr = 1; cyc();
    chk("R9", "count after push+pop", int'(status_word[15:8]), 9);

    // trigger 4
    tsel = 2'b01;
    pop_n(4);
    chk("R4", "flag at count 5 trigger 4", int'(tde_flag), 0);
    pop_n(1);
    chk("R4", "flag at count 4 trigger 4", int'(tde_flag), 1);

    // trigger 2
    tsel = 2'b10; dv = 1; dd = 8'h77; cyc();
    chk("R8", "dma clear at trigger 2", int'(tde_flag), 0);
    pop_n(2);
    chk("R4", "flag at count 3 trigger 2", int'(tde_flag), 0);
    pop_n(1);
    chk("R4", "flag at count 2 trigger 2", int'(tde_flag), 1);
    pop_n(3);
    chk("R2", "tx_valid when drained", int'(tx_valid), 0);

    // both ports at once: CPU wins
    cv = 1; cd = 8'h11; dv = 1; dd = 8'h22; cyc();
    chk("R11", "cpu byte taken", int'(tx_data), 8'h11);
    chk("R11", "single push", int'(status_word[15:8]), 1);
    pop_n(1);

    // random mix against the model
    for (int i = 0; i < 5000; i++) begin
      if (($urandom % 64) == 0) tsel = 2'($urandom);
      cv = ($urandom % 3) == 0; cd = 8'($urandom);
      dv = ($urandom % 3) == 0; dd = 8'($urandom);
      tr = ($urandom % 5) < 2;
      rd = ($urandom % 4) == 0;
      w0 = ($urandom % 4) == 0;
      cyc();
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule